// File: doc/BRIEF.md
# Post-Reset Display Release Controller

This block sits beside the serial receive path of a segment LCD driver and decides when each part of the chip may leave the state that a system reset forces on it. A system reset blanks the display, stops key scanning, holds the stored key data at zero and pins every general-purpose output low. The serial front end reports each finished frame with a one-cycle strobe and a frame code. The code names either the control frame or one of the four display data groups. The four groups cover display bits 1–120, 121–240, 241–360 and 361–480.

The block keeps a sticky record of which frames have arrived since the last reset. Key scanning and the general-purpose outputs are released by the first control frame. The key-data clear level drops at the same moment. The general-purpose outputs then follow the port bits carried by each control frame. The display is switched on only once the control frame and all four display groups have each been seen at least once. They may arrive in any order.

The completion strobe is a plain control pin, not a stream. It cannot be refused and carries no back-pressure. Each strobe is acted on in the cycle it is sampled.

Top module: `disp_release_ctrl`

## Requirements
- R1: While `rst_i` is sampled high, the outputs read `disp_en_o`=0, `scan_en_o`=0, `key_clr_o`=1 and `gp_o`=0 from the following cycle on.
- R2: Frame codes on `xfer_kind_i` are 0 for the control frame and 1, 2, 3, 4 for display groups 1 to 4. A code is counted only in a cycle where `xfer_done_i` is high.
- R3: The cycle after a control frame completes, `scan_en_o` is 1 and `key_clr_o` is 0.
- R4: The cycle after a control frame completes, `gp_o[i]` equals bit i of the `port_bits_i` value sampled with that strobe.
- R5: `disp_en_o` rises in the cycle after the last missing frame arrives, out of the control frame and the four display groups, whatever their order. A repeated frame adds nothing.
- R6: Once released, an output does not return to its reset value until the next reset. Each later control frame reloads `gp_o`.
- R7: If `rst_i` and `xfer_done_i` are high in the same cycle, the strobe is ignored and the reset state results.
- R8: `gp_o` holds its value in any cycle without a completed control frame. This includes display-group frames, whatever their `port_bits_i`.
- R9: Codes 5, 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high system reset |
| xfer_done_i | input | 1 | One-cycle strobe: a serial frame has finished |
| xfer_kind_i | input | KIND_W (3) | Frame code: 0 for control, 1–4 for display groups |
| port_bits_i | input | NUM_PORTS (4) | Port-setting bits carried by the control frame |
| disp_en_o | output | 1 | Display enable |
| scan_en_o | output | 1 | Key-scan enable |
| key_clr_o | output | 1 | Holds the key data register at zero while high |
| gp_o | output | NUM_PORTS (4) | General-purpose output pins |

## Verification
The hardest cases to reach from the ports are those where one frame decides the display state. A reset can land on the very cycle that would otherwise complete the set. The last group can arrive after several repeats of the others. Directed sequences feed the groups in scrambled orders with duplicates and hold back the control frame until last. They also put a control strobe under an asserted reset. A long pseudo-random phase then mixes valid codes, invalid codes and sparse resets. On every cycle, a behavioural model compares all four outputs.

// File: rtl/disp_rel_pkg.sv
package disp_rel_pkg;
  // Slot 0 of the received vector is the control frame; slot g is display group g.
  localparam int CTRL_SLOT = 0;

  // Number of slots needed for a given group count.
  function automatic int slot_count(input int groups);
    return groups + 1;
  endfunction
endpackage

// File: rtl/frame_decode.sv
module frame_decode
  import disp_rel_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int KIND_W     = 3,
  localparam int SLOTS     = slot_count(NUM_GROUPS)
) (
  input  logic              done_i,
  input  logic [KIND_W-1:0] kind_i,
  output logic [SLOTS-1:0]  hit_o
);
  // One decoder per slot; codes above NUM_GROUPS match nothing.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign hit_o[s] = done_i && (kind_i == KIND_W'(s));
  end
endmodule

// File: rtl/recv_tracker.sv
module recv_tracker #(
  parameter int SLOTS = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SLOTS-1:0] hit_i,
  output logic [SLOTS-1:0] seen_o
);
  // Sticky received flags, cleared only by reset (reset wins over hits).
  always_ff @(posedge clk_i) begin
    if (rst_i) seen_o <= '0;
    else       seen_o <= seen_o | hit_i;
  end
endmodule

// File: rtl/port_latch.sv
module port_latch #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 load_i,
  input  logic [NUM_PORTS-1:0] bits_i,
  output logic [NUM_PORTS-1:0] pins_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)       pins_o <= '0;
    else if (load_i) pins_o <= bits_i;
  end
endmodule

// File: rtl/disp_release_ctrl.sv
module disp_release_ctrl
  import disp_rel_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_PORTS  = 4,
  parameter int KIND_W     = $clog2(NUM_GROUPS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 xfer_done_i,
  input  logic [KIND_W-1:0]    xfer_kind_i,
  input  logic [NUM_PORTS-1:0] port_bits_i,
  output logic                 disp_en_o,
  output logic                 scan_en_o,
  output logic                 key_clr_o,
  output logic [NUM_PORTS-1:0] gp_o
);
  localparam int SLOTS = slot_count(NUM_GROUPS);

  logic [SLOTS-1:0] hit;
  logic [SLOTS-1:0] seen;

  frame_decode #(
    .NUM_GROUPS(NUM_GROUPS),
    .KIND_W    (KIND_W)
  ) u_decode (
    .done_i(xfer_done_i),
    .kind_i(xfer_kind_i),
    .hit_o (hit)
  );

  recv_tracker #(
    .SLOTS(SLOTS)
  ) u_track (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .hit_i (hit),
    .seen_o(seen)
  );

  port_latch #(
    .NUM_PORTS(NUM_PORTS)
  ) u_ports (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .load_i(hit[CTRL_SLOT]),
    .bits_i(port_bits_i),
    .pins_o(gp_o)
  );

  // Display needs every slot; scan and key clear need only the control slot.
  assign disp_en_o = &seen;
  assign scan_en_o = seen[CTRL_SLOT];
  assign key_clr_o = ~seen[CTRL_SLOT];
endmodule

// File: rtl/disp_release_ctrl_chk.sv
module disp_release_ctrl_chk #(
  parameter int NUM_PORTS = 4,
  parameter int KIND_W    = 3
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 xfer_done_i,
  input logic [KIND_W-1:0]    xfer_kind_i,
  input logic [NUM_PORTS-1:0] port_bits_i,
  input logic                 disp_en_o,
  input logic                 scan_en_o,
  input logic                 key_clr_o,
  input logic [NUM_PORTS-1:0] gp_o
);
  logic rst_seen_q = 1'b0;

  always @(posedge clk_i) begin
    // R1 R7
    if (rst_seen_q) begin
      reset_state_chk: assert (!disp_en_o && !scan_en_o && key_clr_o && gp_o == '0)
        else $error("reset state not held");
    end
    rst_seen_q <= rst_i;
  end

  // R3
  ctrl_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (xfer_done_i && xfer_kind_i == '0) |=> (scan_en_o && !key_clr_o));

  // R4
  port_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (xfer_done_i && xfer_kind_i == '0) |=> (gp_o == $past(port_bits_i)));

  // R5
  disp_needs_ctrl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    disp_en_o |-> scan_en_o);

  // R5
  disp_rise_on_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(disp_en_o) |-> $past(xfer_done_i));

  // R6
  scan_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    scan_en_o |=> scan_en_o);

  // R6
  disp_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    disp_en_o |=> disp_en_o);

  // R8
  port_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(xfer_done_i && xfer_kind_i == '0) |=> $stable(gp_o));
endmodule

bind disp_release_ctrl disp_release_ctrl_chk #(
  .NUM_PORTS(NUM_PORTS),
  .KIND_W   (KIND_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .xfer_done_i(xfer_done_i),
  .xfer_kind_i(xfer_kind_i),
  .port_bits_i(port_bits_i),
  .disp_en_o  (disp_en_o),
  .scan_en_o  (scan_en_o),
  .key_clr_o  (key_clr_o),
  .gp_o       (gp_o)
);

// File: tb/disp_release_ctrl_tb_top.sv
module disp_release_ctrl_tb_top;
  localparam int NG = 4;
  localparam int NP = 4;
  localparam int KW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          done = 1'b0;
  logic [KW-1:0] kind = '0;
  logic [NP-1:0] bits = '0;
  logic          disp_en, scan_en, key_clr;
  logic [NP-1:0] gp;

  always #10 clk = ~clk;  // 50 MHz

  disp_release_ctrl #(.NUM_GROUPS(NG), .NUM_PORTS(NP), .KIND_W(KW)) dut_i (
    .clk_i(clk), .rst_i(rst), .xfer_done_i(done), .xfer_kind_i(kind),
    .port_bits_i(bits), .disp_en_o(disp_en), .scan_en_o(scan_en),
    .key_clr_o(key_clr), .gp_o(gp)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Behavioural model state
  bit ctl_seen = 0;
  int grp_mask = 0;
  int port_val = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit r, input bit d, input int k, input int b);
    rst  = r;
    done = d;
    kind = KW'(k);
    bits = NP'(b);
    @(posedge clk);
    if (r) begin
      ctl_seen = 0; grp_mask = 0; port_val = 0;
    end else if (d) begin
      if (k == 0) begin
        ctl_seen = 1;
        port_val = b % 16;
      end else if (k >= 1 && k <= NG) begin
        grp_mask = grp_mask | (1 << (k - 1));
      end
    end
    @(negedge clk);
    check({tag, "/R5"}, "disp_en", int'(disp_en), (ctl_seen && grp_mask == 15) ? 1 : 0);
    check({tag, "/R3"}, "scan_en", int'(scan_en), ctl_seen ? 1 : 0);
    check({tag, "/R3"}, "key_clr", int'(key_clr), ctl_seen ? 0 : 1);
    check({tag, "/R4"}, "gp", int'(gp), port_val);
    done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed = 32'h1357_9bdf;
    // R1: reset state
    step("R1", 1, 0, 0, 0);
    step("R1", 1, 0, 0, 0);
    step("R1", 0, 0, 0, 0);
    // R2 R5: groups out of order with repeats, control last
    step("R2", 0, 1, 3, 15);
    step("R2", 0, 1, 1, 15);
    step("R5", 0, 1, 3, 0);
    step("R5", 0, 1, 4, 9);
    step("R5", 0, 1, 2, 0);
    step("R5", 0, 0, 0, 0);
    // R9: invalid codes do nothing
    step("R9", 0, 1, 5, 15);
    step("R9", 0, 1, 6, 15);
    step("R9", 0, 1, 7, 15);
    // R3 R4: control last completes the set
    step("R3", 0, 1, 0, 10);
    step("R4", 0, 0, 0, 5);
    // R6: later control reloads ports, nothing returns to reset
    step("R6", 0, 1, 0, 5);
    step("R6", 0, 1, 0, 0);
    step("R6", 0, 1, 0, 15);
    // R8: display frames and idle strobes leave ports alone
    step("R8", 0, 1, 2, 0);
    step("R8", 0, 0, 0, 3);
    step("R8", 0, 1, 4, 6);
    // R7: reset beats a simultaneous control strobe
    step("R7", 1, 1, 0, 15);
    step("R7", 0, 0, 0, 15);
    step("R7", 1, 1, 1, 0);
    step("R7", 0, 0, 0, 0);
    // R5: control first, then groups descending
    step("R5", 0, 1, 0, 12);
    step("R5", 0, 1, 4, 0);
    step("R5", 0, 1, 3, 0);
    step("R5", 0, 1, 2, 0);
    step("R5", 0, 1, 1, 1);
    // R1: reset after full release, then partial set must not light display
    step("R1", 1, 0, 0, 0);
    step("R5", 0, 1, 1, 0);
    step("R5", 0, 1, 2, 0);
    step("R5", 0, 1, 0, 7);
    step("R5", 0, 1, 3, 0);
    // Mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      seed = seed * 1103515245 + 12345;
      step("R2", ((seed >>> 20) % 41) == 0, ((seed >>> 8) % 3) != 0,
           (seed >>> 12) & 7, (seed >>> 16) & 15);
    end
    summary();
    $finish;
  end
endmodule